// File: doc/BRIEF.md
# Conversion Launch Sequencer

This block starts one conversion or calibration on an analog converter. A command comes in with a 3-bit pointer that names one of eight stored setups. The block presents the pointer on `setup_idx`, and the setup table outside the block answers on `setup_word`. The block registers the fields of that setup and drives the two latch pins that control front-end circuitry. When the setup asks for it, the block waits a fixed settling time. It then pulses the engine start for one cycle, with channel, gain, polarity and rate held steady.

The settling time is 1280 master clocks when the rate-family bit is 0 and 1536 when it is 1. The family bit is sampled once, while the setup is being applied. After the start pulse the block stays busy until the engine reports done. Commands that arrive while the block is busy are dropped.

Top module: `conv_launch_seq`

## Requirements
- R1: When `busy` is low and `cmd_valid` is high at a clock edge, the command is accepted. `busy` is high and `setup_idx` equals `cmd_ptr` in the following cycle.
- R2: `latch_pins` take `setup_word[2:1]` at the end of the first busy cycle (the apply cycle). They keep that value after the operation ends, and they reset to 0.
- R3: At the start pulse, the outputs carry the fields of `setup_word`, and they stay unchanged until the next accepted command. The fields are `eng_pol` = bit 3, `eng_gain` = bits 6:4, `eng_rate` = bits 10:7 and `eng_chan` = bits 12:11. `eng_cal` carries the `cmd_cal` value that was accepted with the command.
- R4: When the setup's delay bit `setup_word[0]` is 0, `eng_start` is high in the same cycle in which `latch_pins` first show the new value.
- R5: When the delay bit is 1 and the sampled family bit is 0, `eng_start` rises exactly 1280 clocks after `latch_pins` change.
- R6: When the delay bit is 1 and the sampled family bit is 1, `eng_start` rises exactly 1536 clocks after `latch_pins` change.
- R7: `rate_family` is sampled only in the apply cycle. Changing it during the wait does not alter the current delay.
- R8: `eng_start` is high for exactly one cycle per accepted command, and only while `busy` is high.
- R9: `busy` stays high after the start pulse until `eng_done` is high. `busy` is low in the cycle after `eng_done` is high.
- R10: A command presented while `busy` is high is ignored. `setup_idx` does not change, and no new operation follows when the current one ends.
- R11: After reset, `busy`, `eng_start` and `latch_pins` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_ptr | input | 3 | Setup pointer for the command |
| cmd_cal | input | 1 | 1 = calibration, 0 = conversion |
| rate_family | input | 1 | Selects the 1536-clock delay when 1 |
| setup_word | input | 13 | Setup selected by `setup_idx`, read combinationally |
| eng_done | input | 1 | Engine has finished the operation |
| setup_idx | output | 3 | Pointer registered when a command is accepted |
| latch_pins | output | 2 | Front-end control pins |
| busy | output | 1 | An operation is in progress |
| eng_start | output | 1 | One-cycle start to the engine |
| eng_cal | output | 1 | Operation type for the engine |
| eng_chan | output | 2 | Channel field |
| eng_gain | output | 3 | Gain field |
| eng_pol | output | 1 | Polarity field |
| eng_rate | output | 4 | Rate field |

## Verification
`busy` and `setup_idx` are due one cycle after the accepting edge, and `latch_pins` one cycle after that. `eng_start` follows in that same cycle when no delay is requested, or exactly 1280 or 1536 cycles later when one is. `busy` falls one cycle after `eng_done`. The bench drives every input on the falling edge and samples on the falling edge, counting edges from the one that changed the latch pins. Each expected cycle number is therefore an exact count and not a window. The bench sweeps every pointer, both operation types, both family values and both delay settings. It toggles `rate_family` and injects extra commands during the wait and run phases.

// File: rtl/clseq_pkg.sv
package clseq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_APPLY = 3'd1,
      ST_WAIT  = 3'd2,
      ST_START = 3'd3,
      ST_RUN   = 3'd4
   } seq_state_t;

   function automatic int unsigned cnt_width(input int unsigned max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction

endpackage

// File: rtl/clseq_ctrl.sv
module clseq_ctrl
   import clseq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_valid,
   input  logic       dly_en,
   input  logic       dly_expired,
   input  logic       eng_done,
   output seq_state_t state
);

   seq_state_t state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:  if (cmd_valid) state_d = ST_APPLY;
         ST_APPLY: state_d = dly_en ? ST_WAIT : ST_START;
         ST_WAIT:  if (dly_expired) state_d = ST_START;
         ST_START: state_d = ST_RUN;
         ST_RUN:   if (eng_done) state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   assign state = state_q;

endmodule

// File: rtl/clseq_settle.sv
module clseq_settle
   import clseq_pkg::*;
#(
   parameter int unsigned BASE_CYC = 1280,
   parameter int unsigned ALT_CYC  = 1536
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic fam_sel,
   output logic expired
);

   localparam int unsigned MAX_CYC = (ALT_CYC > BASE_CYC) ? ALT_CYC : BASE_CYC;
   localparam int unsigned CNT_W   = cnt_width(MAX_CYC);

   if (BASE_CYC < 2) begin : g_bad_base
      $error("clseq_settle: BASE_CYC must be at least 2");
   end
   if (ALT_CYC < 2) begin : g_bad_alt
      $error("clseq_settle: ALT_CYC must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] load_val;

   if (BASE_CYC == ALT_CYC) begin : g_single
      assign load_val = CNT_W'(BASE_CYC - 1);
   end else begin : g_dual
      assign load_val = fam_sel ? CNT_W'(ALT_CYC - 1) : CNT_W'(BASE_CYC - 1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load)           cnt_q <= load_val;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/clseq_setup_regs.sv
module clseq_setup_regs #(
   parameter int unsigned PTR_W   = 3,
   parameter int unsigned CHAN_W  = 2,
   parameter int unsigned GAIN_W  = 3,
   parameter int unsigned RATE_W  = 4,
   parameter int unsigned LATCH_W = 2,
   localparam int unsigned WORD_W = 2 + LATCH_W + GAIN_W + RATE_W + CHAN_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               accept,
   input  logic               capture,
   input  logic [PTR_W-1:0]   cmd_ptr,
   input  logic               cmd_cal,
   input  logic [WORD_W-1:0]  setup_word,
   output logic               dly_en,
   output logic [PTR_W-1:0]   idx,
   output logic               cal,
   output logic [LATCH_W-1:0] latch,
   output logic [CHAN_W-1:0]  chan,
   output logic [GAIN_W-1:0]  gain,
   output logic               pol,
   output logic [RATE_W-1:0]  rate
);

   localparam int unsigned DLY_POS  = 0;
   localparam int unsigned LAT_LSB  = DLY_POS + 1;
   localparam int unsigned POL_POS  = LAT_LSB + LATCH_W;
   localparam int unsigned GAIN_LSB = POL_POS + 1;
   localparam int unsigned RATE_LSB = GAIN_LSB + GAIN_W;
   localparam int unsigned CHAN_LSB = RATE_LSB + RATE_W;

   assign dly_en = setup_word[DLY_POS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx <= '0;
         cal <= 1'b0;
      end else if (accept) begin
         idx <= cmd_ptr;
         cal <= cmd_cal;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chan <= '0;
         gain <= '0;
         pol  <= 1'b0;
         rate <= '0;
      end else if (capture) begin
         chan <= setup_word[CHAN_LSB +: CHAN_W];
         gain <= setup_word[GAIN_LSB +: GAIN_W];
         pol  <= setup_word[POL_POS];
         rate <= setup_word[RATE_LSB +: RATE_W];
      end
   end

   for (genvar gi = 0; gi < LATCH_W; gi++) begin : g_latch
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       latch[gi] <= 1'b0;
         else if (capture) latch[gi] <= setup_word[LAT_LSB + gi];
      end
   end

endmodule

// File: rtl/conv_launch_seq.sv
module conv_launch_seq
   import clseq_pkg::*;
#(
   parameter int unsigned PTR_W    = 3,
   parameter int unsigned CHAN_W   = 2,
   parameter int unsigned GAIN_W   = 3,
   parameter int unsigned RATE_W   = 4,
   parameter int unsigned LATCH_W  = 2,
   parameter int unsigned BASE_CYC = 1280,
   parameter int unsigned ALT_CYC  = 1536,
   localparam int unsigned WORD_W  = 2 + LATCH_W + GAIN_W + RATE_W + CHAN_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_valid,
   input  logic [PTR_W-1:0]   cmd_ptr,
   input  logic               cmd_cal,
   input  logic               rate_family,
   input  logic [WORD_W-1:0]  setup_word,
   input  logic               eng_done,
   output logic [PTR_W-1:0]   setup_idx,
   output logic [LATCH_W-1:0] latch_pins,
   output logic               busy,
   output logic               eng_start,
   output logic               eng_cal,
   output logic [CHAN_W-1:0]  eng_chan,
   output logic [GAIN_W-1:0]  eng_gain,
   output logic               eng_pol,
   output logic [RATE_W-1:0]  eng_rate
);

   if (PTR_W < 1 || CHAN_W < 1 || GAIN_W < 1 || RATE_W < 1 || LATCH_W < 1) begin : g_bad_width
      $error("conv_launch_seq: every field width must be at least 1");
   end

   seq_state_t seq_st;
   logic       dly_en;
   logic       dly_expired;
   logic       accept;
   logic       in_apply;

   assign accept   = (seq_st == ST_IDLE) && cmd_valid;
   assign in_apply = (seq_st == ST_APPLY);

   clseq_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_valid  (cmd_valid),
      .dly_en     (dly_en),
      .dly_expired(dly_expired),
      .eng_done   (eng_done),
      .state      (seq_st)
   );

   clseq_settle #(
      .BASE_CYC(BASE_CYC),
      .ALT_CYC (ALT_CYC)
   ) u_settle (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (in_apply),
      .fam_sel(rate_family),
      .expired(dly_expired)
   );

   clseq_setup_regs #(
      .PTR_W  (PTR_W),
      .CHAN_W (CHAN_W),
      .GAIN_W (GAIN_W),
      .RATE_W (RATE_W),
      .LATCH_W(LATCH_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .capture   (in_apply),
      .cmd_ptr   (cmd_ptr),
      .cmd_cal   (cmd_cal),
      .setup_word(setup_word),
      .dly_en    (dly_en),
      .idx       (setup_idx),
      .cal       (eng_cal),
      .latch     (latch_pins),
      .chan      (eng_chan),
      .gain      (eng_gain),
      .pol       (eng_pol),
      .rate      (eng_rate)
   );

   assign busy      = (seq_st != ST_IDLE);
   assign eng_start = (seq_st == ST_START);

endmodule

// File: rtl/clseq_chk.sv
module clseq_chk
   import clseq_pkg::*;
#(
   parameter int unsigned PTR_W    = 3,
   parameter int unsigned CHAN_W   = 2,
   parameter int unsigned GAIN_W   = 3,
   parameter int unsigned RATE_W   = 4,
   parameter int unsigned LATCH_W  = 2,
   parameter int unsigned BASE_CYC = 1280,
   parameter int unsigned ALT_CYC  = 1536
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cmd_valid,
   input logic               rate_family,
   input logic               eng_done,
   input logic [PTR_W-1:0]   setup_idx,
   input logic [LATCH_W-1:0] latch_pins,
   input logic               busy,
   input logic               eng_start,
   input logic [CHAN_W-1:0]  eng_chan,
   input logic [GAIN_W-1:0]  eng_gain,
   input logic               eng_pol,
   input logic [RATE_W-1:0]  eng_rate,
   input seq_state_t         st
);

   logic [15:0] wait_cnt;
   logic        fam_cap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wait_cnt <= '0;
         fam_cap  <= 1'b0;
      end else begin
         wait_cnt <= (st == ST_WAIT) ? wait_cnt + 16'd1 : 16'd0;
         if (st == ST_APPLY) fam_cap <= rate_family;
      end
   end

   AST_BUSY_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && cmd_valid) |=> busy); // R1
   AST_IDX_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(setup_idx)); // R10
   AST_LATCH_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> $stable(latch_pins)); // R2
   AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |=> !eng_start); // R8
   AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |-> busy); // R8
   AST_FIELDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |=> ($stable(eng_chan) && $stable(eng_gain) && $stable(eng_pol) && $stable(eng_rate))); // R3
   AST_DELAY_BASE: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_START && $past(st) == ST_WAIT && !fam_cap) |-> (wait_cnt == 16'(BASE_CYC))); // R5
   AST_DELAY_ALT: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_START && $past(st) == ST_WAIT && fam_cap) |-> (wait_cnt == 16'(ALT_CYC))); // R6
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_RUN && eng_done) |=> !busy); // R9

endmodule

bind conv_launch_seq clseq_chk #(
   .PTR_W   (PTR_W),
   .CHAN_W  (CHAN_W),
   .GAIN_W  (GAIN_W),
   .RATE_W  (RATE_W),
   .LATCH_W (LATCH_W),
   .BASE_CYC(BASE_CYC),
   .ALT_CYC (ALT_CYC)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cmd_valid  (cmd_valid),
   .rate_family(rate_family),
   .eng_done   (eng_done),
   .setup_idx  (setup_idx),
   .latch_pins (latch_pins),
   .busy       (busy),
   .eng_start  (eng_start),
   .eng_chan   (eng_chan),
   .eng_gain   (eng_gain),
   .eng_pol    (eng_pol),
   .eng_rate   (eng_rate),
   .st         (seq_st)
);

// File: tb/sim_conv_launch_seq.sv
module sim_conv_launch_seq;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [2:0]  cmd_ptr = '0;
   logic        cmd_cal = 1'b0;
   logic        rate_family = 1'b0;
   logic [12:0] setup_word;
   logic        eng_done = 1'b0;
   logic [2:0]  setup_idx;
   logic [1:0]  latch_pins;
   logic        busy;
   logic        eng_start;
   logic        eng_cal;
   logic [1:0]  eng_chan;
   logic [2:0]  eng_gain;
   logic        eng_pol;
   logic [3:0]  eng_rate;

   logic [12:0] tbl [8];
   int          n_cmp = 0;
   int          n_bad = 0;
   int          prev_lat = 0;
   bit          done_all = 0;

   always #10 clk = ~clk;

   assign setup_word = tbl[setup_idx];

   conv_launch_seq u0 (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ptr(cmd_ptr),
      .cmd_cal(cmd_cal), .rate_family(rate_family), .setup_word(setup_word),
      .eng_done(eng_done), .setup_idx(setup_idx), .latch_pins(latch_pins),
      .busy(busy), .eng_start(eng_start), .eng_cal(eng_cal), .eng_chan(eng_chan),
      .eng_gain(eng_gain), .eng_pol(eng_pol), .eng_rate(eng_rate)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic run_op(input int ptr, input bit cal, input bit fam, input bit dly, input int n);
      int lat, pol, gain, rate, chan, k, exp_d;
      lat  = (ptr + n) % 4;
      pol  = (ptr ^ n) & 1;
      gain = (3 * ptr + n) % 8;
      rate = (ptr + 5 * n) % 16;
      chan = (ptr + 2 * n) % 4;
      tbl[ptr] = 13'(int'(dly) | (lat << 1) | (pol << 3) | (gain << 4) | (rate << 7) | (chan << 11));
      exp_d = fam ? 1536 : 1280;

      @(negedge clk);
      cmd_valid = 1'b1; cmd_ptr = 3'(ptr); cmd_cal = cal; rate_family = fam;
      @(negedge clk);
      cmd_valid = 1'b0;
      chk("R1 busy after accept", int'(busy), 1);
      chk("R1 setup_idx", int'(setup_idx), ptr);
      chk("R2 latch held during apply", int'(latch_pins), prev_lat);
      @(negedge clk);
      rate_family = ~fam;   // R7: change after the apply cycle
      chk("R2 latch updated", int'(latch_pins), lat);
      if (!dly) begin
         chk("R4 start with new latch", int'(eng_start), 1);
      end else begin
         k = 0;
         while (!eng_start && k < 3000) begin
            if (k == 3) begin cmd_valid = 1'b1; cmd_ptr = 3'(ptr ^ 1); end
            if (k == 4) cmd_valid = 1'b0;
            @(negedge clk);
            k++;
         end
         chk(fam ? "R6 R7 delay length alt" : "R5 R7 delay length base", k, exp_d);
         chk("R10 idx kept during wait", int'(setup_idx), ptr);
      end
      chk("R3 chan", int'(eng_chan), chan);
      chk("R3 gain", int'(eng_gain), gain);
      chk("R3 pol", int'(eng_pol), pol);
      chk("R3 rate", int'(eng_rate), rate);
      chk("R3 cal", int'(eng_cal), int'(cal));
      cmd_valid = 1'b1; cmd_ptr = 3'(ptr ^ 2);
      @(negedge clk);
      cmd_valid = 1'b0;
      chk("R8 start one cycle", int'(eng_start), 0);
      chk("R9 busy until done", int'(busy), 1);
      chk("R10 idx kept during run", int'(setup_idx), ptr);
      @(negedge clk);
      eng_done = 1'b1;
      @(negedge clk);
      eng_done = 1'b0;
      chk("R9 idle after done", int'(busy), 0);
      chk("R2 latch held after op", int'(latch_pins), lat);
      chk("R3 fields held after op", int'(eng_rate), rate);
      @(negedge clk);
      chk("R10 no queued op", int'(busy), 0);
      prev_lat = lat;
   endtask

   initial begin
      for (int i = 0; i < 8; i++) tbl[i] = '0;
      repeat (3) @(negedge clk);
      chk("R11 busy reset", int'(busy), 0);
      chk("R11 start reset", int'(eng_start), 0);
      chk("R11 latch reset", int'(latch_pins), 0);
      rst_n = 1'b1;
      begin
         int n;
         n = 0;
         for (int f = 0; f < 2; f++)
            for (int d = 0; d < 2; d++)
               for (int p = 0; p < 8; p++)
                  for (int c = 0; c < 2; c++) begin
                     run_op(p, c[0], f[0], d[0], n);
                     n++;
                  end
      end
      done_all = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done_all) begin
         n_cmp++;
         n_bad++;
         $display("FAIL R9 watchdog expired: actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule